// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

The block is a memory-mapped watchdog. A 32-bit down-counter steps once for each pulse on a 1 MHz tick-enable input while its run bit is set. Software writes a reload value and then writes a fixed key word to a dedicated restart register. The key copies the reload value into the counter. A stray write of any other value leaves the counter alone, so software that has lost control is unlikely to keep the timer serviced by accident.

A tick that finds the counter at zero while it runs is an expiry. The block issues a one-cycle expiry strobe and reloads the counter, so a watchdog that is left unserviced fires again after every period. Control bits decide which requests follow the strobe: a system reset request, an interrupt request, or an external-signal pulse. The reset-scope field and the secondary-boot flag are presented on ports for the system reset controller.

The usual setup order is: clear control, write reload, write the key, then write control with the run bit set.

Top module: `wdog_top`

## Requirements
- R1: After a synchronous reset, every register reads zero and all request outputs are low.
- R2: Register map by word offset. 0x00 status reads the live counter and ignores writes. 0x04 reload reads back what was written. 0x08 restart always reads zero. 0x0C control keeps bits 7:0 and reads zero above them. An address with bits 1:0 nonzero selects no register.
- R3: Writing exactly 0x0000_4755 to offset 0x08 loads the counter from the reload register, whether or not the run bit is set. This load takes precedence over a tick in the same cycle.
- R4: A write to offset 0x08 of any other value, including a value whose low 16 bits are 0x4755, leaves the counter unchanged.
- R5: Control bit 0 is the run bit. While it is set, each clock with the tick high decrements a nonzero counter by one.
- R6: While control bit 0 is clear, the counter holds its value through ticks and no expiry occurs.
- R7: A tick that finds the running counter at zero raises `expire` for exactly the following cycle and reloads the counter. An unserviced watchdog therefore expires every reload+1 ticks.
- R8: An expiry drives `reset_req` in the same cycle only when control bit 1 is set, `irq_req` only when bit 2 is set, and `ext_pulse` only when bit 3 is set. Control bit 4 (clock source) is stored only.
- R9: `reset_scope` always equals control bits 6:5 (0 SoC, 1 full chip, 2 CPU only). `boot_alt` always equals control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1m | input | 1 | One-cycle 1 MHz count enable |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| expire | output | 1 | One-cycle expiry strobe |
| reset_req | output | 1 | Reset request pulse |
| irq_req | output | 1 | Interrupt request pulse |
| ext_pulse | output | 1 | External-signal pulse |
| reset_scope | output | 2 | Selected reset scope |
| boot_alt | output | 1 | Secondary boot image requested |

## Verification
A wrong count or a missed key load shows up directly in the status register at the next access. A wrong count also shows up as an expiry strobe one or more ticks away from the reload+1 count, and the bench checks for that after every tick. A corrupted control register shows up at once on `reset_scope` and `boot_alt`, and at the next expiry as the wrong set of request pulses. A load that was missed only when the key write coincided with a tick is caught by a test that drives both in the same cycle.

// File: rtl/wdog_pkg.sv
// Package: shared widths, register offsets and the control-register layout
// for the keyed-restart watchdog. Assumes word-aligned 32-bit accesses.
package wdog_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CTRL_W  = 8;
    localparam int IDX_W   = ADDR_W - 2;

    localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;

    // Word indices (byte offset >> 2); the ordering is part of the bus map.
    localparam logic [IDX_W-1:0] IDX_STATUS  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_RELOAD  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_RESTART = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL    = 2'd3;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'd0,
        SCOPE_CHIP = 2'd1,
        SCOPE_CPU  = 2'd2,
        SCOPE_RSVD = 2'd3
    } scope_e;

    // Control bits, MSB first; the bit positions are decoded by software.
    typedef struct packed {
        logic   boot_alt;   // 7
        scope_e scope;      // 6:5
        logic   clk_sel;    // 4
        logic   ext_en;     // 3
        logic   irq_en;     // 2
        logic   rst_en;     // 1
        logic   run;        // 0
    } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file and read mux. It holds reload and control, decodes the keyed
// restart, and returns the live counter on status reads.
// Assumes: single-cycle writes, reads are combinational from bus_addr.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CTRL_W,
    parameter logic [DW-1:0] KEY = RESTART_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] reload,
    output ctrl_t         ctrl,
    output logic          load
);
    localparam int IW = AW - 2;

    logic          aligned;
    logic [IW-1:0] idx;
    logic          wr_reload, wr_restart, wr_ctrl;

    // Decode the word index and the write targets.
    always_comb begin
        aligned    = (bus_addr[1:0] == 2'b00);
        idx        = bus_addr[AW-1:2];
        wr_reload  = bus_wr && aligned && (idx == IDX_RELOAD);
        wr_restart = bus_wr && aligned && (idx == IDX_RESTART);
        wr_ctrl    = bus_wr && aligned && (idx == IDX_CTRL);
        load       = wr_restart && (bus_wdata == KEY);
    end

    // Reload register update.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= '0;
        else if (wr_reload) reload <= bus_wdata;
    end

    // Control register update; bits above CW are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CW-1:0]);
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_STATUS: bus_rdata = cnt;
                IDX_RELOAD: bus_rdata = reload;
                IDX_CTRL:   bus_rdata = {{(DW-CW){1'b0}}, ctrl};
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_BAD_KEY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == {IDX_RESTART, 2'b00} && bus_wdata != KEY) |-> !load); // R4
    AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl == $past(bus_wdata[CW-1:0]))); // R2
endmodule

// File: rtl/wdog_counter.sv
// Down-counter. A key load takes priority. Otherwise a tick at zero while
// running is an expiry that reloads, and any other running tick decrements.
// Assumes: tick is a one-cycle enable in the clk domain.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic [DW-1:0] reload,
    output logic [DW-1:0] cnt,
    output logic          fire
);
    // Expiry condition for this cycle.
    always_comb fire = run && tick && !load && (cnt == '0);

    // Counter state update.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load || fire)  cnt <= reload;
        else if (run && tick)   cnt <= cnt - 1'b1;
    end

    AST_KEY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(reload))); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt)); // R6
    AST_NO_FIRE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !fire); // R6
endmodule

// File: rtl/wdog_expiry.sv
// Output stage: registers the expiry and gates each request with its
// control enable.
// Assumes: the control bits are stable in the cycle of the expiry.
module wdog_expiry
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fire,
    input  ctrl_t ctrl,
    output logic  expire,
    output logic  reset_req,
    output logic  irq_req,
    output logic  ext_pulse
);
    // Register the strobe and the gated requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire    <= 1'b0;
            reset_req <= 1'b0;
            irq_req   <= 1'b0;
            ext_pulse <= 1'b0;
        end else begin
            expire    <= fire;
            reset_req <= fire && ctrl.rst_en;
            irq_req   <= fire && ctrl.irq_en;
            ext_pulse <= fire && ctrl.ext_en;
        end
    end

    AST_RESET_NEEDS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> expire); // R8
    AST_IRQ_NEEDS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> expire); // R8
    AST_EXPIRE_FOLLOWS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> expire); // R7
endmodule

// File: rtl/wdog_top.sv
// Watchdog top: joins the register file, the down-counter and the output
// stage, and brings out the reset scope and the boot flag from control.
// Assumes: tick_1m is synchronous to clk and lasts one cycle.
module wdog_top
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1m,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              expire,
    output logic              reset_req,
    output logic              irq_req,
    output logic              ext_pulse,
    output logic [1:0]        reset_scope,
    output logic              boot_alt
);
    logic [DATA_W-1:0] cnt, reload;
    ctrl_t             ctrl;
    logic              load, fire;

    wdog_regs #(.DW(DATA_W), .AW(ADDR_W), .CW(CTRL_W), .KEY(RESTART_KEY)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cnt(cnt), .bus_rdata(bus_rdata),
        .reload(reload), .ctrl(ctrl), .load(load)
    );

    wdog_counter #(.DW(DATA_W)) i_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick_1m), .run(ctrl.run),
        .load(load), .reload(reload), .cnt(cnt), .fire(fire)
    );

    wdog_expiry i_expiry (
        .clk(clk), .rst_n(rst_n), .fire(fire), .ctrl(ctrl),
        .expire(expire), .reset_req(reset_req), .irq_req(irq_req),
        .ext_pulse(ext_pulse)
    );

    // Static configuration outputs.
    always_comb begin
        reset_scope = ctrl.scope;
        boot_alt    = ctrl.boot_alt;
    end

    AST_SCOPE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_scope == bus_rdata[6:5] || bus_addr != 4'hC); // R9
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1m = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire, reset_req, irq_req, ext_pulse, boot_alt;
    logic [1:0]  reset_scope;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_top i_wdog_top (
        .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .expire(expire), .reset_req(reset_req), .irq_req(irq_req),
        .ext_pulse(ext_pulse), .reset_scope(reset_scope), .boot_alt(boot_alt)
    );

    // Vectors: {ctrl[7:0], reload[7:0]}
    localparam logic [15:0] VEC [4] = '{16'h03_03, 16'h05_00, 16'h2F_05, 16'hC1_02};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic tick();
        tick_1m = 1'b1;
        @(posedge clk); @(negedge clk);
        tick_1m = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(a[3:0], v);
            chk(v == 0, "R1 reg after reset", v, 0);
        end
        chk({expire, reset_req, irq_req, ext_pulse, boot_alt, reset_scope} == 0,
            "R1 outputs after reset", {expire, reset_req, irq_req, ext_pulse}, 0);

        // Table walk: R3 R5 R7 R8 R9
        for (int k = 0; k < 4; k++) begin
            logic [7:0] c, rl;
            c  = VEC[k][15:8];
            rl = VEC[k][7:0];
            wr(4'hC, 32'h0);
            wr(4'h4, {24'h0, rl});
            wr(4'h8, 32'h4755);
            rd(4'h0, v);
            chk(v == rl, "R3 key load while stopped", v, rl);
            wr(4'hC, {24'h0, c});
            chk(reset_scope == c[6:5], "R9 scope", reset_scope, c[6:5]);
            chk(boot_alt == c[7], "R9 boot flag", boot_alt, c[7]);
            for (int i = 0; i < rl; i++) begin
                tick();
                chk(!expire, "R7 early expiry", expire, 0);
                rd(4'h0, v);
                chk(v == rl - 1 - i, "R5 decrement", v, rl - 1 - i);
            end
            tick();
            chk(expire, "R7 expiry at zero", expire, 1);
            chk(reset_req == c[1], "R8 reset_req gating", reset_req, c[1]);
            chk(irq_req == c[2], "R8 irq_req gating", irq_req, c[2]);
            chk(ext_pulse == c[3], "R8 ext_pulse gating", ext_pulse, c[3]);
            rd(4'h0, v);
            chk(v == rl, "R7 reload on expiry", v, rl);
            idle();
            chk(!expire, "R7 strobe one cycle", expire, 0);
        end

        // R7 periodic re-fire (last vector, reload 2, still running)
        tick(); tick();
        chk(!expire, "R7 no expiry before period", expire, 0);
        tick();
        chk(expire, "R7 second expiry", expire, 1);
        chk(!reset_req && !irq_req, "R8 requests off", {reset_req, irq_req}, 0);

        // R4 wrong keys
        tick();
        rd(4'h0, v);
        chk(v == 1, "R4 count before bad key", v, 1);
        wr(4'h8, 32'h4756);
        rd(4'h0, v);
        chk(v == 1, "R4 bad key ignored", v, 1);
        wr(4'h8, 32'h0001_4755);
        rd(4'h0, v);
        chk(v == 1, "R4 upper bits make key invalid", v, 1);

        // R3 key wins over a simultaneous tick
        tick_1m = 1'b1;
        wr(4'h8, 32'h4755);
        tick_1m = 1'b0;
        rd(4'h0, v);
        chk(v == 2, "R3 key beats tick", v, 2);

        // R6 stopped counter holds
        wr(4'hC, 32'hC0);
        repeat (4) begin
            tick();
            chk(!expire, "R6 no expiry while stopped", expire, 0);
        end
        rd(4'h0, v);
        chk(v == 2, "R6 hold while stopped", v, 2);

        // R2 map details
        wr(4'h0, 32'h0);
        rd(4'h0, v);
        chk(v == 2, "R2 status write ignored", v, 2);
        rd(4'h8, v);
        chk(v == 0, "R2 restart reads zero", v, 0);
        rd(4'h4, v);
        chk(v == 2, "R2 reload readback", v, 2);
        wr(4'h5, 32'h77);
        rd(4'h4, v);
        chk(v == 2, "R2 unaligned write ignored", v, 2);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v);
        chk(v == 32'hFF, "R2 control upper bits zero", v, 32'hFF);
        chk(reset_scope == 2'd3 && boot_alt, "R9 all-ones control", {boot_alt, reset_scope}, 3'b111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule